// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day as a 32-bit seconds field and a 31-bit sub-second field. It feeds time stamping logic elsewhere in a network interface. Software programs it through a plain write strobe and a registered read strobe. It sets a per-tick sub-second step and a rate addend, and it loads or shifts the time with one-shot command bits that the hardware clears by itself.

The time advances in one of two rate modes. In coarse mode the step is added on every clock. In fine mode a 32-bit phase accumulator adds the active addend on every clock, and the step is applied only on the clocks where that accumulator carries out. Trimming the addend therefore trims the frequency. The sub-second field rolls over either at 2^31 in binary units of roughly 0.466 ns, or at 10^9 in whole nanoseconds. A rollover carries into the seconds field, and the seconds field wraps modulo 2^32.

Offsets are applied as a modular add. To subtract, software writes the two's complement of the seconds and the rollover value minus the nanoseconds, and sets a subtract flag. The hardware then borrows one second whenever the sub-second sum does not wrap.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time reads 0 s / 0 ns, and the control word at address 0 reads 0. With the step register at address 1 still 0, the time stays at zero.
- R2: Coarse mode is selected when control bit 0 is clear. In this mode every clock adds the step value from address 1 to the combined time, for any step from 0 to 255.
- R3: A write to address 1 with a value above 255 stores 255. Values of 255 or less are stored unchanged, and a read of address 1 returns the stored value.
- R4: Binary rollover is selected when control bit 1 is clear. When the sub-second sum reaches 2^31, it wraps by subtracting 2^31 and adds one second in the same clock.
- R5: Decimal rollover is selected when control bit 1 is set. When the sub-second sum reaches 10^9, it wraps by subtracting 10^9 and adds one second in the same clock.
- R6: The seconds field wraps from 2^32-1 to 0.
- R7: Fine mode is selected when control bit 0 is set. In this mode the step is applied only on clocks where the 32-bit accumulator, which adds the active addend each clock, carries out. Over K clocks with K times the addend equal to M times 2^32, exactly M steps are applied.
- R8: A write to the addend staging register at address 2 has no effect on the rate until control bit 4 is written as 1. After reset the active addend is 0, so fine mode does not advance the time.
- R9: Writing control bit 2 as 1 loads the seconds from address 3 and the sub-second value from bits 30:0 of address 4 on the next clock edge. No step is applied on that edge.
- R10: Writing control bit 3 as 1 adds the offset at addresses 3 and 4 to the time on the next clock edge, together with that clock's normal step. The offset's sub-second part must not exceed the rollover value.
- R11: When bit 31 of address 4 is set, the offset update borrows one second unless the sub-second sum wraps. This makes a complement-encoded offset subtract exactly.
- R12: Command bits 2, 3 and 4 read back as 1 on the clock after they are written and as 0 afterwards. A command write that arrives while the same bit is still set is ignored.
- R13: A read strobe returns, one clock later, the live seconds (address 5) or sub-second value (address 6) as they stood at the strobed edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the clock after the strobe |
| sys_sec | output | 32 | Live seconds |
| sys_ns | output | 31 | Live sub-second count |

## Verification
The bench sweeps every step value in both rollover formats. A wrong carry compare, such as `>` instead of `>=`, leaves the sub-second field sitting at the rollover value and shifts one second late. It loads times just below each rollover and at the last second, so a missing carry or a seconds field that saturates shows up at once. Offset subtracts are run with and without a sub-second wrap; a design that forgets the borrow lands exactly one second high. Fine-mode windows are sized so the tick count is exact whatever the accumulator phase. A back-to-back repeated command shows whether a second load, which would freeze the time for one clock, is wrongly accepted.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 3;
  localparam int unsigned SEC_W = 32;
  localparam int unsigned NS_W  = 31;

  typedef enum logic [AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_STEP   = 3'd1,
    RA_ADDEND = 3'd2,
    RA_OFSSEC = 3'd3,
    RA_OFSNS  = 3'd4,
    RA_NOWSEC = 3'd5,
    RA_NOWNS  = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  localparam int unsigned CB_FINE  = 0;
  localparam int unsigned CB_DEC   = 1;
  localparam int unsigned CB_LOAD  = 2;
  localparam int unsigned CB_SHIFT = 3;
  localparam int unsigned CB_RATE  = 4;
  localparam int unsigned CTRL_W   = 5;

endpackage

// File: rtl/ptp_tc_rst_sync.sv
module ptp_tc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [NS_W-1:0]   now_ns,
  output logic [DW-1:0]     rd_data,
  output logic              fine_o,
  output logic              dec_o,
  output logic [STEP_W-1:0] step_o,
  output logic [DW-1:0]     addend_stage_o,
  output logic [SEC_W-1:0]  ofs_sec_o,
  output logic [NS_W-1:0]   ofs_ns_o,
  output logic              ofs_sub_o,
  output logic              load_go_o,
  output logic              shift_go_o,
  output logic              rate_go_o
);
  localparam logic [DW-1:0] STEP_MAX = DW'((1 << STEP_W) - 1);

  logic              fine_q, fine_d, dec_q, dec_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [DW-1:0]     stage_q, stage_d;
  logic [SEC_W-1:0]  osec_q, osec_d;
  logic [NS_W-1:0]   ons_q, ons_d;
  logic              osub_q, osub_d;
  logic              load_q, load_d, shift_q, shift_d, rate_q, rate_d;
  logic [DW-1:0]     rd_q, rd_d;
  logic              rd_ce;

  always_comb begin
    fine_d  = fine_q;
    dec_d   = dec_q;
    step_d  = step_q;
    stage_d = stage_q;
    osec_d  = osec_q;
    ons_d   = ons_q;
    osub_d  = osub_q;
    load_d  = 1'b0;
    shift_d = 1'b0;
    rate_d  = 1'b0;
    if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        RA_CTRL: begin
          fine_d  = wr_data[CB_FINE];
          dec_d   = wr_data[CB_DEC];
          load_d  = wr_data[CB_LOAD]  & ~load_q;
          shift_d = wr_data[CB_SHIFT] & ~shift_q;
          rate_d  = wr_data[CB_RATE]  & ~rate_q;
        end
        RA_STEP:   step_d  = (wr_data > STEP_MAX) ? STEP_MAX[STEP_W-1:0] : wr_data[STEP_W-1:0];
        RA_ADDEND: stage_d = wr_data;
        RA_OFSSEC: osec_d  = wr_data;
        RA_OFSNS: begin
          ons_d  = wr_data[NS_W-1:0];
          osub_d = wr_data[DW-1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_ce = rd_en;
    unique case (reg_addr_e'(rd_addr))
      RA_CTRL:   rd_d = {{(DW-CTRL_W){1'b0}}, rate_q, shift_q, load_q, dec_q, fine_q};
      RA_STEP:   rd_d = {{(DW-STEP_W){1'b0}}, step_q};
      RA_ADDEND: rd_d = stage_q;
      RA_OFSSEC: rd_d = osec_q;
      RA_OFSNS:  rd_d = {osub_q, ons_q};
      RA_NOWSEC: rd_d = now_sec;
      RA_NOWNS:  rd_d = {1'b0, now_ns};
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q  <= 1'b0;
      dec_q   <= 1'b0;
      step_q  <= '0;
      stage_q <= '0;
      osec_q  <= '0;
      ons_q   <= '0;
      osub_q  <= 1'b0;
      load_q  <= 1'b0;
      shift_q <= 1'b0;
      rate_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      fine_q  <= fine_d;
      dec_q   <= dec_d;
      step_q  <= step_d;
      stage_q <= stage_d;
      osec_q  <= osec_d;
      ons_q   <= ons_d;
      osub_q  <= osub_d;
      load_q  <= load_d;
      shift_q <= shift_d;
      rate_q  <= rate_d;
      if (rd_ce) rd_q <= rd_d;
    end
  end

  assign rd_data        = rd_q;
  assign fine_o         = fine_q;
  assign dec_o          = dec_q;
  assign step_o         = step_q;
  assign addend_stage_o = stage_q;
  assign ofs_sec_o      = osec_q;
  assign ofs_ns_o       = ons_q;
  assign ofs_sub_o      = osub_q;
  assign load_go_o      = load_q;
  assign shift_go_o     = shift_q;
  assign rate_go_o      = rate_q;
endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine,
  input  logic             rate_go,
  input  logic [ACC_W-1:0] addend_stage,
  output logic [ACC_W-1:0] addend_act,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, acc_d, add_q, add_d;
  logic             carry;
  logic             add_ce;

  always_comb begin
    {carry, acc_d} = {1'b0, acc_q} + {1'b0, add_q};
    add_ce = rate_go;
    add_d  = addend_stage;
    tick   = fine ? carry : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      add_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (add_ce) add_q <= add_d;
    end
  end

  assign addend_act = add_q;
endmodule

// File: rtl/ptp_tc_time.sv
module ptp_tc_time
  import ptp_tc_pkg::*;
#(
  parameter int unsigned STEP_W   = 8,
  parameter int unsigned DEC_ROLL = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic              load_go,
  input  logic              shift_go,
  input  logic [SEC_W-1:0]  ofs_sec,
  input  logic [NS_W-1:0]   ofs_ns,
  input  logic              ofs_sub,
  output logic [SEC_W-1:0]  sec,
  output logic [NS_W-1:0]   ns
);
  localparam logic [DW-1:0] ROLL_DEC = DW'(DEC_ROLL);
  localparam logic [DW-1:0] ROLL_BIN = DW'(1) << NS_W;

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [NS_W-1:0]  ns_q, ns_d;
  logic [DW-1:0]    roll, inc, s1, n1, s2;
  logic [NS_W-1:0]  n2;
  logic             c1, c2, t_ce;

  always_comb begin
    roll = dec ? ROLL_DEC : ROLL_BIN;
    inc  = tick ? {{(DW-STEP_W){1'b0}}, step} : '0;
    s1   = {1'b0, ns_q} + inc;
    c1   = (s1 >= roll);
    n1   = c1 ? (s1 - roll) : s1;
    s2   = n1 + {1'b0, ofs_ns};
    c2   = (s2 >= roll);
    n2   = c2 ? NS_W'(s2 - roll) : s2[NS_W-1:0];
    t_ce = tick | load_go | shift_go;
    if (load_go) begin
      sec_d = ofs_sec;
      ns_d  = ofs_ns;
    end else if (shift_go) begin
      sec_d = sec_q + ofs_sec + SEC_W'(c1) + SEC_W'(c2) - SEC_W'(ofs_sub);
      ns_d  = n2;
    end else begin
      sec_d = sec_q + SEC_W'(c1);
      ns_d  = n1[NS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (t_ce) begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  assign sec = sec_q;
  assign ns  = ns_q;
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned STEP_W   = 8,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned DEC_ROLL = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [SEC_W-1:0] sys_sec,
  output logic [NS_W-1:0]  sys_ns
);
  logic              rst_sync_n;
  logic              fine_w, dec_w, tick_w;
  logic [STEP_W-1:0] step_w;
  logic [DW-1:0]     stage_w;
  logic [ACC_W-1:0]  addend_w;
  logic [SEC_W-1:0]  ofs_sec_w;
  logic [NS_W-1:0]   ofs_ns_w;
  logic              ofs_sub_w, load_go_w, shift_go_w, rate_go_w;

  ptp_tc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ptp_tc_regs #(.STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .now_sec(sys_sec), .now_ns(sys_ns), .rd_data(rd_data),
    .fine_o(fine_w), .dec_o(dec_w), .step_o(step_w),
    .addend_stage_o(stage_w), .ofs_sec_o(ofs_sec_w), .ofs_ns_o(ofs_ns_w),
    .ofs_sub_o(ofs_sub_w), .load_go_o(load_go_w), .shift_go_o(shift_go_w),
    .rate_go_o(rate_go_w)
  );

  ptp_tc_rate #(.ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst_n(rst_sync_n), .fine(fine_w), .rate_go(rate_go_w),
    .addend_stage(ACC_W'(stage_w)), .addend_act(addend_w), .tick(tick_w)
  );

  ptp_tc_time #(.STEP_W(STEP_W), .DEC_ROLL(DEC_ROLL)) u_time (
    .clk(clk), .rst_n(rst_sync_n), .dec(dec_w), .tick(tick_w), .step(step_w),
    .load_go(load_go_w), .shift_go(shift_go_w), .ofs_sec(ofs_sec_w),
    .ofs_ns(ofs_ns_w), .ofs_sub(ofs_sub_w), .sec(sys_sec), .ns(sys_ns)
  );
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
  import ptp_tc_pkg::*;
#(
  parameter int unsigned STEP_W   = 8,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned DEC_ROLL = 1000000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fine,
  input logic              dec,
  input logic [STEP_W-1:0] step,
  input logic              load_go,
  input logic              shift_go,
  input logic              rate_go,
  input logic [DW-1:0]     stage,
  input logic [ACC_W-1:0]  addend,
  input logic [SEC_W-1:0]  ofs_sec,
  input logic [NS_W-1:0]   ofs_ns,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic [SEC_W-1:0]  sec,
  input logic [NS_W-1:0]   ns
);
  localparam logic [NS_W-1:0] NS_DEC = NS_W'(DEC_ROLL);

  AST_COARSE_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!fine && !dec && !load_go && !shift_go) |=> ({sec, ns} == $past({sec, ns}) + 63'($past(step)))); // R2
  AST_DEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (dec && (ns < NS_DEC) && !load_go && !shift_go) |=> (ns < NS_DEC)); // R5
  AST_FINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (fine && (addend == '0) && !load_go && !shift_go) |=> ($stable(sec) && $stable(ns))); // R8
  AST_RATE_XFER: assert property (@(posedge clk) disable iff (!rst_n) rate_go |=> (addend == ACC_W'($past(stage)))); // R8
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rate_go |=> $stable(addend)); // R8
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n) load_go |=> ((sec == $past(ofs_sec)) && (ns == $past(ofs_ns)))); // R9
  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) load_go |=> !load_go); // R12
  AST_SHIFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) shift_go |=> !shift_go); // R12
  AST_RATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rate_go |=> !rate_go); // R12
  AST_LIVE_NS: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && (rd_addr == 3'd6)) |=> (rd_data == {1'b0, $past(ns)})); // R13
  AST_LIVE_SEC: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && (rd_addr == 3'd5)) |=> (rd_data == $past(sec))); // R13
endmodule

bind ptp_time_counter ptp_time_counter_chk #(
  .STEP_W(STEP_W), .ACC_W(ACC_W), .DEC_ROLL(DEC_ROLL)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fine(fine_w), .dec(dec_w), .step(step_w),
  .load_go(load_go_w), .shift_go(shift_go_w), .rate_go(rate_go_w),
  .stage(stage_w), .addend(addend_w), .ofs_sec(ofs_sec_w), .ofs_ns(ofs_ns_w),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sec(sys_sec), .ns(sys_ns)
);

// File: tb/test_ptp_time_counter.sv
`timescale 1ns/1ps
module test_ptp_time_counter;
  localparam logic [31:0] DEC_R = 32'd1000000000;
  localparam logic [31:0] BIN_R = 32'h8000_0000;
  localparam logic [31:0] M_FINE = 32'h1, M_DEC = 32'h2;
  localparam logic [31:0] C_LOAD = 32'h4, C_SHIFT = 32'h8, C_RATE = 32'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, sys_sec;
  logic [30:0] sys_ns;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ptp_time_counter i_ptp_time_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sys_sec(sys_sec), .sys_ns(sys_ns)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] tnow(input logic [31:0] roll);
    return 64'(sys_sec) * 64'(roll) + 64'(sys_ns);
  endfunction

  task automatic load_time(input logic [31:0] mode, input logic [31:0] s, input logic [31:0] n);
    wr(3'd3, s);
    wr(3'd4, n);
    wr(3'd0, mode | C_LOAD);
    cyc(1);
  endtask

  task automatic expect_time(input string tag, input logic [31:0] s, input logic [30:0] n);
    chk(sys_sec == s, tag, 64'(sys_sec), 64'(s));
    chk(sys_ns == n, tag, 64'(sys_ns), 64'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t0, t1;
    logic [30:0] n0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    expect_time("R1 reset time", 32'd0, 31'd0);
    rd(3'd0, d);
    chk(d == 32'd0, "R1 ctrl", 64'(d), 64'd0);
    cyc(5);
    expect_time("R1 idle", 32'd0, 31'd0);

    // R8 fine mode with no addend transferred: stalled
    wr(3'd1, 32'd10);
    wr(3'd2, 32'h8000_0000);
    wr(3'd0, M_FINE);
    t0 = tnow(BIN_R); cyc(10); t1 = tnow(BIN_R);
    chk(t1 == t0, "R8 zero addend stall", t1 - t0, 64'd0);

    // R7 fine mode windows
    for (int k = 1; k <= 4; k++) begin
      wr(3'd2, 32'h1 << (32 - k));
      wr(3'd0, M_FINE | C_RATE);
      cyc(2);
      t0 = tnow(BIN_R); cyc(4 << k); t1 = tnow(BIN_R);
      chk(t1 - t0 == 64'd40, "R7 fine window", t1 - t0, 64'd40);
    end
    wr(3'd2, 32'hC000_0000);
    wr(3'd0, M_FINE | C_RATE);
    cyc(2);
    t0 = tnow(BIN_R); cyc(16); t1 = tnow(BIN_R);
    chk(t1 - t0 == 64'd120, "R7 fine 3/4 rate", t1 - t0, 64'd120);
    wr(3'd2, 32'hFFFF_FFFF);
    t0 = tnow(BIN_R); cyc(16); t1 = tnow(BIN_R);
    chk(t1 - t0 == 64'd120, "R8 staging without command", t1 - t0, 64'd120);
    wr(3'd0, 32'd0);

    // R3 step saturation
    wr(3'd1, 32'd300);      rd(3'd1, d); chk(d == 32'd255, "R3 sat 300", 64'(d), 64'd255);
    wr(3'd1, 32'h8000_0001); rd(3'd1, d); chk(d == 32'd255, "R3 sat big", 64'(d), 64'd255);
    wr(3'd1, 32'd256);      rd(3'd1, d); chk(d == 32'd255, "R3 sat 256", 64'(d), 64'd255);
    wr(3'd1, 32'd254);      rd(3'd1, d); chk(d == 32'd254, "R3 pass 254", 64'(d), 64'd254);
    wr(3'd1, 32'd300);
    t0 = tnow(BIN_R); cyc(4); t1 = tnow(BIN_R);
    chk(t1 - t0 == 64'd1020, "R3 saturated rate", t1 - t0, 64'd1020);

    // R2 coarse sweep, binary rollover
    load_time(32'd0, 32'd0, 32'h7FFF_F000);
    for (int s = 0; s < 256; s++) begin
      wr(3'd1, 32'(s));
      t0 = tnow(BIN_R); cyc(8); t1 = tnow(BIN_R);
      chk(t1 - t0 == 64'(8 * s), "R2 R4 binary sweep", t1 - t0, 64'(8 * s));
    end
    // R2 coarse sweep, decimal rollover
    load_time(M_DEC, 32'd0, DEC_R - 32'd1000);
    for (int s = 0; s < 256; s++) begin
      wr(3'd1, 32'(s));
      t0 = tnow(DEC_R); cyc(8); t1 = tnow(DEC_R);
      chk(t1 - t0 == 64'(8 * s), "R2 R5 decimal sweep", t1 - t0, 64'(8 * s));
    end

    // R9 load and R4 binary rollover edge
    wr(3'd1, 32'd4);
    load_time(32'd0, 32'd5, BIN_R - 32'd3);
    expect_time("R9 load binary", 32'd5, 31'(BIN_R - 32'd3));
    cyc(1);
    expect_time("R4 binary wrap", 32'd6, 31'd1);
    // R5 decimal rollover edge
    load_time(M_DEC, 32'd7, DEC_R - 32'd3);
    expect_time("R9 load decimal", 32'd7, 31'(DEC_R - 32'd3));
    cyc(1);
    expect_time("R5 decimal wrap", 32'd8, 31'd1);
    // R6 seconds wrap
    load_time(M_DEC, 32'hFFFF_FFFF, DEC_R - 32'd2);
    cyc(1);
    expect_time("R6 seconds wrap", 32'd0, 31'd2);

    // R12 pending readback and repeated command ignored
    wr(3'd3, 32'd50); wr(3'd4, 32'd500);
    wr(3'd0, M_DEC | C_LOAD);
    rd(3'd0, d);
    chk(d[2] == 1'b1, "R12 pending set", 64'(d[2]), 64'd1);
    rd(3'd0, d);
    chk(d[2] == 1'b0, "R12 self clear", 64'(d[2]), 64'd0);
    wr(3'd0, M_DEC | C_LOAD);
    wr(3'd0, M_DEC | C_LOAD);
    expect_time("R12 first load", 32'd50, 31'd500);
    cyc(1);
    expect_time("R12 repeat ignored", 32'd50, 31'd504);

    // R10 add offset, decimal, frozen clock
    wr(3'd1, 32'd0);
    load_time(M_DEC, 32'd10, 32'd100);
    wr(3'd3, 32'd3); wr(3'd4, 32'd999999950);
    wr(3'd0, M_DEC | C_SHIFT); cyc(1);
    expect_time("R10 add decimal", 32'd14, 31'd50);
    // R11 subtract with borrow
    load_time(M_DEC, 32'd10, 32'd100);
    wr(3'd3, 32'hFFFF_FFFE); wr(3'd4, 32'h8000_0000 | (DEC_R - 32'd200));
    wr(3'd0, M_DEC | C_SHIFT); cyc(1);
    expect_time("R11 subtract borrow", 32'd7, 31'd999999900);
    load_time(M_DEC, 32'd10, 32'd100);
    wr(3'd3, 32'hFFFF_FFFB); wr(3'd4, 32'h8000_0000 | DEC_R);
    wr(3'd0, M_DEC | C_SHIFT); cyc(1);
    expect_time("R11 subtract zero ns", 32'd5, 31'd100);
    load_time(32'd0, 32'd10, 32'd100);
    wr(3'd3, 32'hFFFF_FFFE); wr(3'd4, 32'h8000_0000 | (BIN_R - 32'd200));
    wr(3'd0, C_SHIFT); cyc(1);
    expect_time("R11 subtract binary", 32'd7, 31'(BIN_R - 32'd100));
    // R10 offset with running clock keeps its tick
    wr(3'd1, 32'd7);
    t0 = tnow(BIN_R);
    wr(3'd3, 32'd1); wr(3'd4, 32'd0); wr(3'd0, C_SHIFT); cyc(3);
    t1 = tnow(BIN_R);
    chk(t1 - t0 == 64'(BIN_R) + 64'd42, "R10 add with tick", t1 - t0, 64'(BIN_R) + 64'd42);

    // R13 live reads
    wr(3'd1, 32'd3);
    n0 = sys_ns; rd(3'd6, d);
    chk(d == {1'b0, n0}, "R13 live ns", 64'(d), 64'(n0));
    n0 = sys_ns; rd(3'd6, t0[31:0]);
    chk(t0[31:0] == d + 32'd3, "R13 ns advances", 64'(t0[31:0]), 64'(d + 32'd3));
    t1[31:0] = sys_sec; rd(3'd5, d);
    chk(d == t1[31:0], "R13 live sec", 64'(d), 64'(t1[31:0]));

    report();
    $finish;
  end
endmodule